// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with a small synchronous register port. Software programs a 10-bit timeout period, clears the halt bit to start counting, and must write the kick register (any data value) before the count runs out. The count moves one step per pulse on the `tick` input. That input comes from a prescaler outside the block, with a nominal step of about 0.6 s. A period of 1023 then gives roughly 613 s, and a period of 3 gives about 2 s.

Expiry is handled in two stages. The first expiry sets a status flag, can raise a one-cycle system-management interrupt request, and restarts the countdown. If a second expiry follows without a kick, the block issues a one-cycle reset request. A no-reboot control suppresses that request. A board strap can hold the no-reboot control on, and software cannot clear it while the strap is held. Status flags are cleared by writing a 1 to their position.

Register map (3-bit address, 16-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit 0 halt, bit 1 local SMI enable, bit 2 global SMI enable, bit 3 no-reboot |
| 1 | KICK | write-only; reads return 0 |
| 2 | PERIOD | bits 9:0 period |
| 3 | STATUS | bit 0 first timeout, bit 1 second timeout, bit 2 boot status |
| 4 | COUNT | bits 9:0 current count |

Top module: `wdt_two_stage`

## Requirements
- R1: A write of any data value to address 1 (KICK) loads the count with the programmed period on the following clock edge, and reads of address 1 return 0.
- R2: While CTRL bit 0 (halt) is 1, ticks do not change the count. After the halt bit is cleared, counting resumes from the frozen value.
- R3: PERIOD stores only data bits 9:0. Bits 15:10 read as 0 and writes to them are ignored. A PERIOD write does not change the running count.
- R4: Each `tick` pulse with halt clear lowers a nonzero count by one. Expiry occurs on the tick that finds the count at 0, so a period P expires on the (P+1)-th tick after a kick.
- R5: The first expiry sets STATUS bit 0 and reloads the count with the period. It also pulses `smi_req` for one cycle, but only when CTRL bits 1 and 2 are both 1.
- R6: A second consecutive expiry sets STATUS bit 1 and reloads the count. If the effective no-reboot bit is 0, it also sets STATUS bit 2 and pulses `reset_req` for exactly one cycle. Otherwise no reset request is issued.
- R7: Writing to STATUS (address 3) clears each bit whose data bit is 1 and leaves the others unchanged. A new event in the same cycle wins over the clear.
- R8: After reset, CTRL reads 0x0001 (halted), PERIOD reads 0x0004, COUNT reads 4, STATUS reads 0, and neither request output is asserted.
- R9: A kick cancels a pending first timeout, so the next expiry is again treated as a first expiry.
- R10: While `strap_nr_lock` is 1, CTRL bit 3 reads 1 and reset requests are suppressed, whatever software wrote. Once the strap drops, the written value takes effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-step enable from the external prescaler |
| strap_nr_lock | input | 1 | Strap that forces no-reboot on |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered, valid the cycle after `rd_en` |
| smi_req | output | 1 | One-cycle interrupt request on a first expiry |
| reset_req | output | 1 | One-cycle reset request on a second expiry |

## Verification
Every register result lands on the first clock edge after its stimulus. A write changes the register on the edge that samples it. Read data appears on the edge after `rd_en`. A tick that expires the count raises the status bit and the request pulse together, one edge after the tick. The driver pushes each expected read value when it issues the read. The monitor pops and compares that value at the falling edge after the capturing edge. Request pulses are counted at falling edges, which also catches a pulse held for two cycles. Pulse totals are compared only after the counting edge has passed.

// File: rtl/wdt_pkg.sv
// Shared constants for the two-stage watchdog: register addresses and
// bit positions inside the control and status registers.
package wdt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_KICK   = 3'd1,
        A_PERIOD = 3'd2,
        A_STATUS = 3'd3,
        A_COUNT  = 3'd4
    } wdt_addr_e;

    // control register bit positions
    localparam int C_HALT     = 0;
    localparam int C_SMI_LOC  = 1;
    localparam int C_SMI_GLB  = 2;
    localparam int C_NOREBOOT = 3;

    // status register bit positions
    localparam int S_FIRST  = 0;
    localparam int S_SECOND = 1;
    localparam int S_BOOT   = 2;
    localparam int STS_W    = 3;

endpackage

// File: rtl/wdt_counter.sv
// Countdown and stage tracking for the watchdog.
// Assumes: tick is a one-cycle enable; kick has priority over a tick in the
// same cycle; period changes take effect at the next load only.
module wdt_counter #(
    parameter int PER_W   = 10,
    parameter int PER_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             kick,
    input  logic [PER_W-1:0] period,
    input  logic             noreboot,
    output logic [PER_W-1:0] count,
    output logic             ev_first,
    output logic             ev_second,
    output logic             ev_boot
);
    localparam logic [PER_W-1:0] PER_INIT = PER_W'(PER_RST);

    logic [PER_W-1:0] count_q;
    logic             stage_q;   // a first timeout is pending
    logic             step;
    logic             expire;

    // decode whether this cycle steps or expires the count
    always_comb begin
        step      = tick && !halt && !kick;
        expire    = step && (count_q == '0);
        ev_first  = expire && !stage_q;
        ev_second = expire && stage_q;
        ev_boot   = ev_second && !noreboot;
    end

    // count register and pending-stage flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= PER_INIT;
            stage_q <= 1'b0;
        end else if (kick) begin
            count_q <= period;
            stage_q <= 1'b0;
        end else if (expire) begin
            count_q <= period;
            stage_q <= !stage_q;
        end else if (step) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/wdt_regs.sv
// Register file of the watchdog: control, period, write-one-to-clear status
// and a registered read mux. Assumes one access per cycle on the port.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PER_W   = 10,
    parameter int PER_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              strap_lock,
    input  logic              ev_first,
    input  logic              ev_second,
    input  logic              ev_boot,
    input  logic [PER_W-1:0]  count_in,
    output logic              halt,
    output logic              smi_loc_en,
    output logic              smi_glb_en,
    output logic              noreboot,
    output logic [PER_W-1:0]  period,
    output logic              kick,
    output logic [STS_W-1:0]  status,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [PER_W-1:0] PER_INIT = PER_W'(PER_RST);

    logic              halt_q, sloc_q, sglb_q, nr_q;
    logic [PER_W-1:0]  period_q;
    logic [STS_W-1:0]  sts_set;
    logic              sts_wr;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // strobe decode for write-triggered actions
    always_comb begin
        kick   = wr_en && (addr == A_KICK);
        sts_wr = wr_en && (addr == A_STATUS);
    end

    // control register; no-reboot is forced on by the strap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
            sloc_q <= 1'b0;
            sglb_q <= 1'b0;
            nr_q   <= 1'b0;
        end else if (wr_en && addr == A_CTRL) begin
            halt_q <= wdata[C_HALT];
            sloc_q <= wdata[C_SMI_LOC];
            sglb_q <= wdata[C_SMI_GLB];
            nr_q   <= wdata[C_NOREBOOT];
        end
    end

    // period register keeps only the low field
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= PER_INIT;
        else if (wr_en && addr == A_PERIOD)
            period_q <= wdata[PER_W-1:0];
    end

    // map counter events onto status bit positions
    always_comb begin
        sts_set           = '0;
        sts_set[S_FIRST]  = ev_first;
        sts_set[S_SECOND] = ev_second;
        sts_set[S_BOOT]   = ev_boot;
    end

    // one sticky flag per status bit, set wins over write-one-clear
    for (genvar i = 0; i < STS_W; i++) begin : g_sts
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (sts_set[i])
                flag_q <= 1'b1;
            else if (sts_wr && wdata[i])
                flag_q <= 1'b0;
        end
        assign status[i] = flag_q;
    end

    // read mux over the register map
    always_comb begin
        rd_mux = '0;
        case (wdt_addr_e'(addr))
            A_CTRL: begin
                rd_mux[C_HALT]     = halt_q;
                rd_mux[C_SMI_LOC]  = sloc_q;
                rd_mux[C_SMI_GLB]  = sglb_q;
                rd_mux[C_NOREBOOT] = nr_q | strap_lock;
            end
            A_PERIOD: rd_mux[PER_W-1:0] = period_q;
            A_STATUS: rd_mux[STS_W-1:0] = status;
            A_COUNT:  rd_mux[PER_W-1:0] = count_in;
            default:  rd_mux = '0;
        endcase
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    assign halt       = halt_q;
    assign smi_loc_en = sloc_q;
    assign smi_glb_en = sglb_q;
    assign noreboot   = nr_q | strap_lock;
    assign period     = period_q;
    assign rdata      = rdata_q;

endmodule

// File: rtl/wdt_two_stage.sv
// Two-stage watchdog top: register file, countdown, and registered
// interrupt / reset request pulses. Assumes tick comes from a prescaler
// in the same clock domain.
module wdt_two_stage #(
    parameter int DATA_W  = 16,
    parameter int PER_W   = 10,
    parameter int PER_RST = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       strap_nr_lock,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [wdt_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       smi_req,
    output logic                       reset_req
);
    import wdt_pkg::*;

    logic                  halt, smi_loc_en, smi_glb_en, noreboot, kick;
    logic [PER_W-1:0]      period, count;
    logic [STS_W-1:0]      status;
    logic                  ev_first, ev_second, ev_boot;
    logic                  smi_q, rst_q;

    wdt_regs #(
        .DATA_W (DATA_W),
        .PER_W  (PER_W),
        .PER_RST(PER_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .strap_lock(strap_nr_lock),
        .ev_first  (ev_first),
        .ev_second (ev_second),
        .ev_boot   (ev_boot),
        .count_in  (count),
        .halt      (halt),
        .smi_loc_en(smi_loc_en),
        .smi_glb_en(smi_glb_en),
        .noreboot  (noreboot),
        .period    (period),
        .kick      (kick),
        .status    (status),
        .rdata     (rdata)
    );

    wdt_counter #(
        .PER_W  (PER_W),
        .PER_RST(PER_RST)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .halt     (halt),
        .kick     (kick),
        .period   (period),
        .noreboot (noreboot),
        .count    (count),
        .ev_first (ev_first),
        .ev_second(ev_second),
        .ev_boot  (ev_boot)
    );

    // request pulses, aligned with the status update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            smi_q <= ev_first && smi_loc_en && smi_glb_en;
            rst_q <= ev_boot;
        end
    end

    assign smi_req   = smi_q;
    assign reset_req = rst_q;

endmodule

// File: rtl/wdt_two_stage_chk.sv
// Temporal checks on the watchdog, bound into the top module.
module wdt_two_stage_chk #(
    parameter int PER_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             kick,
    input logic [PER_W-1:0] count,
    input logic [PER_W-1:0] period,
    input logic             noreboot,
    input logic             strap_nr_lock,
    input logic [2:0]       status,
    input logic             smi_req,
    input logic             reset_req
);
    // R1: a kick loads the period on the next edge
    a_r1_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == $past(period)));

    // R2: halted count stays put without a kick
    a_r2_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> (count == $past(count)));

    // R5: interrupt request arrives with the first-timeout flag
    a_r5_smi_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> status[0]);

    // R6: reset request arrives with second-timeout and boot flags
    a_r6_reset_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (status[1] && status[2]));

    // R6: reset request lasts one cycle
    a_r6_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R6: no-reboot suppresses the request
    a_r6_noreboot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        noreboot |=> !reset_req);

    // R10: strap forces no-reboot on
    a_r10_strap_forces: assert property (@(posedge clk) disable iff (!rst_n)
        strap_nr_lock |-> noreboot);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.PER_W(PER_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt         (halt),
    .kick         (kick),
    .count        (count),
    .period       (period),
    .noreboot     (noreboot),
    .strap_nr_lock(strap_nr_lock),
    .status       (status),
    .smi_req      (smi_req),
    .reset_req    (reset_req)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        strap_nr_lock = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        smi_req, reset_req;

    int checks = 0;
    int failures = 0;
    int smi_cnt = 0;
    int rst_cnt = 0;
    int rst_wide = 0;
    logic rst_prev = 1'b0;
    logic mon_pend = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    wdt_two_stage u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .strap_nr_lock(strap_nr_lock),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .smi_req(smi_req), .reset_req(reset_req)
    );

    always @(posedge clk) mon_pend <= rd_en;

    // monitor: pulse counting and read comparison
    always @(negedge clk) begin
        if (smi_req) smi_cnt++;
        if (reset_req) begin
            rst_cnt++;
            if (rst_prev) rst_wide++;
        end
        rst_prev = reset_req;
        if (mon_pend) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                failures++;
                $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic cnt_chk(input string t, input int act_smi, input int act_rst,
                           input int e_smi, input int e_rst);
        checks++;
        if (act_smi != e_smi || act_rst != e_rst) begin
            failures++;
            $display("FAIL %s: smi=%0d rst=%0d expected smi=%0d rst=%0d",
                     t, act_smi, act_rst, e_smi, e_rst);
        end
    endtask

    task automatic pulses(input string t, input int e_smi, input int e_rst);
        @(posedge clk); #1;
        cnt_chk(t, smi_cnt, rst_cnt, e_smi, e_rst);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        rd(3'd0, 16'h0001, "R8 ctrl");
        rd(3'd2, 16'h0004, "R8 period");
        rd(3'd3, 16'h0000, "R8 status");
        rd(3'd4, 16'h0004, "R8 count");
        pulses("R8 no requests", 0, 0);
        // R2 halted after reset
        tk(10);
        rd(3'd4, 16'h0004, "R2 halted count");
        // R3 period field
        wr(3'd2, 16'hFC05);
        rd(3'd2, 16'h0005, "R3 period low field");
        rd(3'd4, 16'h0004, "R3 count untouched");
        // R1 kick and R4 decrement
        wr(3'd0, 16'h0006);
        wr(3'd1, 16'hBEEF);
        rd(3'd4, 16'h0005, "R1 kick loads");
        rd(3'd1, 16'h0000, "R1 kick reads zero");
        tk(3);
        rd(3'd4, 16'h0002, "R4 three steps");
        wr(3'd1, 16'h0000);
        rd(3'd4, 16'h0005, "R1 kick reloads");
        // R2 halt mid-count then resume
        tk(2);
        wr(3'd0, 16'h0007);
        tk(4);
        rd(3'd4, 16'h0003, "R2 frozen");
        wr(3'd0, 16'h0006);
        tk(1);
        rd(3'd4, 16'h0002, "R2 resumed");
        // R4 boundary and R5 first expiry
        wr(3'd1, 16'h1234);
        tk(5);
        rd(3'd4, 16'h0000, "R4 at zero");
        rd(3'd3, 16'h0000, "R4 no expiry yet");
        tk(1);
        rd(3'd3, 16'h0001, "R5 first flag");
        rd(3'd4, 16'h0005, "R5 reload");
        pulses("R5 smi pulse", 1, 0);
        // R6 second expiry
        tk(6);
        rd(3'd3, 16'h0007, "R6 second flags");
        rd(3'd4, 16'h0005, "R6 reload");
        pulses("R6 reset pulse", 1, 1);
        checks++;
        if (rst_wide != 0) begin
            failures++;
            $display("FAIL R6 pulse width: wide=%0d expected 0", rst_wide);
        end
        // R7 write-one-to-clear
        wr(3'd3, 16'h0001);
        rd(3'd3, 16'h0006, "R7 clear bit0");
        wr(3'd3, 16'h0006);
        rd(3'd3, 16'h0000, "R7 clear rest");
        // R5 gating: only local enable
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'h0000);
        tk(6);
        rd(3'd3, 16'h0001, "R5 flag without smi");
        pulses("R5 smi gated", 1, 1);
        // R9 kick cancels pending stage
        wr(3'd1, 16'h0000);
        tk(6);
        rd(3'd3, 16'h0001, "R9 first again");
        pulses("R9 no reset", 1, 1);
        wr(3'd3, 16'h0007);
        // R6 no-reboot suppression
        wr(3'd0, 16'h000A);
        wr(3'd1, 16'h0000);
        tk(12);
        rd(3'd3, 16'h0003, "R6 suppressed flags");
        pulses("R6 suppressed", 1, 1);
        wr(3'd3, 16'h0007);
        // R10 strap lock
        strap_nr_lock = 1'b1;
        wr(3'd0, 16'h0002);
        rd(3'd0, 16'h000A, "R10 locked readback");
        wr(3'd1, 16'h0000);
        tk(12);
        rd(3'd3, 16'h0003, "R10 locked flags");
        pulses("R10 locked no reset", 1, 1);
        wr(3'd3, 16'h0007);
        strap_nr_lock = 1'b0;
        rd(3'd0, 16'h0002, "R10 released readback");
        wr(3'd1, 16'h0000);
        tk(12);
        rd(3'd3, 16'h0007, "R10 released reset flags");
        pulses("R10 released reset", 1, 2);
        repeat (4) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule